// File: doc/BRIEF.md
# Trimmed Seconds Counter with Alarm

This block keeps wall-clock time in whole seconds. A reference enable pulse, nominally at 32.768 kHz and already synchronous to the bus clock, drives a programmable divider. Each time the divider completes a period, it emits one tick, nominally once per second. The tick advances a 32-bit seconds counter. To correct a reference crystal that runs slightly fast, a trim value swallows single reference pulses in a programmable number of divider periods out of every frame of 1023 periods. This lowers the tick rate by a fraction of a part per thousand.

Software uses a small memory-mapped register set to program the divider and the trim, to load or read the seconds value, and to set an alarm time. A status register holds two sticky event flags, one for alarm and one for tick. Each flag has its own interrupt enable, and a single level interrupt combines them.

Top module: `rtc_trim_alarm`

## Requirements
- R1: After reset the seconds counter reads 0, the alarm reads 0, the trim register reads 0x0000_7FFF (divide count 0x7FFF, delete count 0), the status register reads 0 and `irq` is low.
- R2: With delete count 0 and divide count C, one tick occurs every C+1 accepted reference pulses, and each tick adds exactly one to the seconds counter.
- R3: Cycles in which `ref_en` is low do not advance the divider or the counter.
- R4: The trim register holds the divide count C in bits [15:0] and the delete count D in bits [25:16]. In each of the first D periods of every 1023-period frame, the first reference pulse is swallowed, so those periods take C+2 pulses.
- R5: The period index wraps after 1023 periods, so period 1023 counted from a restart is again period 0 of a new frame and is subject to deletion.
- R6: Every tick sets status bit 1 (tick seen).
- R7: Status bit 0 (alarm seen) is set when a tick makes the seconds counter equal to the alarm register. Loading the counter with the alarm value directly does not set it.
- R8: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 to either flag leaves it unchanged.
- R9: Status bits 2 (alarm interrupt enable) and 3 (tick interrupt enable) are plain read/write. `irq` is high exactly when (bit0 AND bit2) OR (bit1 AND bit3).
- R10: A write to the counter register loads the written value at that clock edge and restarts the divider and the frame index. No tick occurs at that edge.
- R11: Registers are decoded at byte offsets alarm 0x00, counter 0x04, trim 0x08 and status 0x10. Trim bits [31:26] read 0, and any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | One-cycle enable per reference clock period |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Level interrupt |

## Verification
The divider is run with the reference enable held high across windows that end one pulse short of a tick and exactly on it. This covers several divide counts and delete counts of 0, 1, 2 and 3, so an off-by-one in the divide ratio shows up apart from a deletion applied to the wrong periods. A run of 1025 and 1026 pulses with divide count 0 and one deletion separates a frame of 1023 periods from one of 1024. The event flags are driven through tick-only, alarm-match and direct-load cases, each followed by clear writes with mixed ones and zeros, so that set, hold and clear can each be told apart at `irq`.

// File: rtl/rtc_pkg.sv
// Package: shared constants for the trimmed seconds counter.
// Assumes byte addressing with 32-bit registers.
package rtc_pkg;
    parameter int ADDR_W = 5;
    parameter int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ALARM  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TRIM   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h10;

    // status bit positions (decoded by software)
    localparam int ST_ALARM    = 0;
    localparam int ST_TICK     = 1;
    localparam int ST_ALARM_EN = 2;
    localparam int ST_TICK_EN  = 3;
    localparam int N_EVENTS    = 2;
endpackage

// File: rtl/rtc_divider.sv
// Module: rtc_divider
// Divides the reference enable by div_c+1 and emits a one-cycle tick.
// In the first del_d periods of each FRAME_LEN-period frame it swallows
// the first reference pulse. Assumes ref_en is synchronous to clk.
module rtc_divider #(
    parameter int DIV_W     = 16,
    parameter int DEL_W     = 10,
    parameter int FRAME_LEN = 1023
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_c,
    input  logic [DEL_W-1:0] del_d,
    output logic             tick
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam int CMP_W = (IDX_W > DEL_W) ? IDX_W : DEL_W;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);

    logic [DIV_W-1:0] pulse_cnt;
    logic [IDX_W-1:0] frame_idx;
    logic             swallowed;
    logic             swallow_now;
    logic             accept;

    // a period inside the delete window loses its first pulse
    always_comb begin
        swallow_now = ref_en && !swallowed && !restart
                      && (CMP_W'(frame_idx) < CMP_W'(del_d));
        accept      = ref_en && !swallow_now && !restart;
        tick        = accept && (pulse_cnt >= div_c);
    end

    // period counter, frame index and per-period swallow marker
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pulse_cnt <= '0;
            frame_idx <= '0;
            swallowed <= 1'b0;
        end else if (swallow_now) begin
            swallowed <= 1'b1;
        end else if (tick) begin
            pulse_cnt <= '0;
            swallowed <= 1'b0;
            frame_idx <= (frame_idx == IDX_LAST) ? '0 : frame_idx + 1'b1;
        end else if (accept) begin
            pulse_cnt <= pulse_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_seconds.sv
// Module: rtc_seconds
// Seconds counter with a direct load and alarm compare. A load wins over a
// tick at the same edge. The alarm hit is flagged only for a tick increment.
module rtc_seconds #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] count,
    output logic             alarm_hit
);
    logic [CNT_W-1:0] next_val;

    // incremented value and its compare against the alarm
    always_comb begin
        next_val  = count + 1'b1;
        alarm_hit = tick && !load && (next_val == alarm);
    end

    // seconds register
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick)
            count <= next_val;
    end
endmodule

// File: rtl/rtc_regs.sv
// Module: rtc_regs
// Register decode for alarm, trim and status, plus read mux and interrupt.
// Event flags are sticky and cleared by writing one; a set wins over a clear
// at the same edge. The counter itself lives in rtc_seconds; this block only
// raises the load strobe.
module rtc_regs
    import rtc_pkg::*;
#(
    parameter int             DIV_W     = 16,
    parameter int             DEL_W     = 10,
    parameter logic [15:0]    DIV_RESET = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] count,
    input  logic              tick,
    input  logic              alarm_hit,
    output logic              count_load,
    output logic [DATA_W-1:0] alarm,
    output logic [DIV_W-1:0]  div_c,
    output logic [DEL_W-1:0]  del_d,
    output logic [3:0]        status,
    output logic              irq
);
    logic                wr;
    logic [N_EVENTS-1:0] evt_set;
    logic [N_EVENTS-1:0] evt_flag;
    logic [1:0]          evt_en;

    // write strobe and per-register decode
    always_comb begin
        wr         = bus_sel && bus_we;
        count_load = wr && (bus_addr == OFS_COUNT);
        evt_set    = '0;
        evt_set[ST_ALARM] = alarm_hit;
        evt_set[ST_TICK]  = tick;
    end

    // alarm and trim registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= '0;
            div_c <= DIV_RESET[DIV_W-1:0];
            del_d <= '0;
        end else if (wr) begin
            if (bus_addr == OFS_ALARM)
                alarm <= bus_wdata;
            if (bus_addr == OFS_TRIM) begin
                div_c <= bus_wdata[DIV_W-1:0];
                del_d <= bus_wdata[16 +: DEL_W];
            end
        end
    end

    // one sticky write-one-to-clear flag per event source
    for (genvar i = 0; i < N_EVENTS; i++) begin : g_evt
        always_ff @(posedge clk) begin
            if (!rst_n)
                evt_flag[i] <= 1'b0;
            else if (evt_set[i])
                evt_flag[i] <= 1'b1;
            else if (wr && bus_addr == OFS_STATUS && bus_wdata[i])
                evt_flag[i] <= 1'b0;
        end
    end

    // interrupt enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_en <= '0;
        else if (wr && bus_addr == OFS_STATUS)
            evt_en <= bus_wdata[ST_TICK_EN:ST_ALARM_EN];
    end

    // status view, interrupt and read mux
    always_comb begin
        status = {evt_en, evt_flag};
        irq    = |(evt_flag & evt_en);
        unique case (bus_addr)
            OFS_ALARM:  bus_rdata = alarm;
            OFS_COUNT:  bus_rdata = count;
            OFS_TRIM:   bus_rdata = DATA_W'({del_d, div_c});
            OFS_STATUS: bus_rdata = DATA_W'(status);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_trim_alarm.sv
// Module: rtc_trim_alarm (top)
// Trimmed seconds counter with alarm and interrupt. Assumes ref_en is a
// one-cycle pulse already synchronous to clk.
module rtc_trim_alarm
    import rtc_pkg::*;
#(
    parameter int FRAME_LEN = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int DIV_W = 16;
    localparam int DEL_W = 10;

    logic [DIV_W-1:0]  div_c;
    logic [DEL_W-1:0]  del_d;
    logic [DATA_W-1:0] alarm_val;
    logic [DATA_W-1:0] sec_count;
    logic [3:0]        status_bits;
    logic              sec_tick;
    logic              cnt_load;
    logic              alarm_hit;

    rtc_divider #(.DIV_W(DIV_W), .DEL_W(DEL_W), .FRAME_LEN(FRAME_LEN)) u_div (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .restart(cnt_load),
        .div_c(div_c), .del_d(del_d), .tick(sec_tick)
    );

    rtc_seconds #(.CNT_W(DATA_W)) u_sec (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(cnt_load),
        .load_val(bus_wdata), .alarm(alarm_val), .count(sec_count),
        .alarm_hit(alarm_hit)
    );

    rtc_regs #(.DIV_W(DIV_W), .DEL_W(DEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(sec_count), .tick(sec_tick), .alarm_hit(alarm_hit),
        .count_load(cnt_load), .alarm(alarm_val), .div_c(div_c),
        .del_d(del_d), .status(status_bits), .irq(irq)
    );
endmodule

// File: rtl/rtc_checker.sv
// Module: rtc_checker
// Temporal properties of the seconds counter, flags and interrupt.
module rtc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ref_en,
    input logic        cnt_wr,
    input logic [31:0] wdata,
    input logic        tick,
    input logic [31:0] count,
    input logic [31:0] alarm,
    input logic [3:0]  status,
    input logic        irq
);
    // R2: a tick without a load adds one
    assert_tick_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> count == $past(count) + 32'd1);

    // R3: no reference pulse and no load keeps the counter
    assert_ref_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_en && !cnt_wr) |=> $stable(count));

    // R6: tick leaves the tick flag set
    assert_hz_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> status[1]);

    // R7: the alarm flag rises only on a match
    assert_alarm_eq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> count == alarm);

    // R9: interrupt needs an enabled source
    assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (status[2] || status[3]));

    // R10: load takes the bus value
    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> count == $past(wdata));
endmodule

bind rtc_trim_alarm rtc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .cnt_wr(cnt_load),
    .wdata(bus_wdata), .tick(sec_tick), .count(sec_count),
    .alarm(alarm_val), .status(status_bits), .irq(irq)
);

// File: tb/test_rtc_trim_alarm.sv
module test_rtc_trim_alarm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #5ns clk = ~clk;

    rtc_trim_alarm i_rtc_trim_alarm (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] c;
        logic [9:0]  d;
        logic [15:0] pulses;
        logic [31:0] expect_cnt;
    } vec_t;

    // divide count, delete count, pulses after restart, expected seconds
    localparam vec_t VEC [15] = '{
        '{16'd3, 10'd0, 16'd3,    32'd0},    // R2 one short
        '{16'd3, 10'd0, 16'd4,    32'd1},    // R2 exact
        '{16'd3, 10'd0, 16'd12,   32'd3},    // R2 three periods
        '{16'd0, 10'd0, 16'd7,    32'd7},    // R2 ratio one
        '{16'd9, 10'd0, 16'd30,   32'd3},    // R2 ratio ten
        '{16'd3, 10'd2, 16'd4,    32'd0},    // R4 deleted period short
        '{16'd3, 10'd2, 16'd5,    32'd1},    // R4 deleted period exact
        '{16'd3, 10'd2, 16'd10,   32'd2},    // R4 two deleted periods
        '{16'd3, 10'd2, 16'd14,   32'd3},    // R4 then normal period
        '{16'd0, 10'd1, 16'd1,    32'd0},    // R4 swallow only
        '{16'd0, 10'd1, 16'd2,    32'd1},    // R4
        '{16'd0, 10'd3, 16'd6,    32'd3},    // R4
        '{16'd0, 10'd1, 16'd1024, 32'd1023}, // R5 full frame
        '{16'd0, 10'd1, 16'd1025, 32'd1023}, // R5 new frame swallows
        '{16'd0, 10'd1, 16'd1026, 32'd1024}  // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1ns;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1ns;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic run_ref(input int n);
        @(negedge clk);
        ref_en = 1'b1;
        repeat (n) @(posedge clk);
        #1ns;
        ref_en = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1ns rst_n = 1'b1;

        // R1 reset values
        bus_read(5'h04, rd); check("R1 count", rd, 32'h0);
        bus_read(5'h00, rd); check("R1 alarm", rd, 32'h0);
        bus_read(5'h08, rd); check("R1 trim", rd, 32'h0000_7FFF);
        bus_read(5'h10, rd); check("R1 status", rd, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // vector table: R2 R4 R5 and R10 restart
        for (int i = 0; i < 15; i++) begin
            bus_write(5'h08, {6'b0, VEC[i].d, VEC[i].c});
            bus_write(5'h04, 32'h0);
            run_ref(int'(VEC[i].pulses));
            bus_read(5'h04, rd);
            check($sformatf("R2/R4/R5 vector %0d", i), rd, VEC[i].expect_cnt);
        end

        // R3: no reference pulses, counter holds
        bus_write(5'h08, 32'h0);
        bus_write(5'h04, 32'd50);
        repeat (20) @(posedge clk);
        bus_read(5'h04, rd); check("R3 hold", rd, 32'd50);

        // R10: load mid-period restarts divider
        bus_write(5'h08, 32'd3);
        bus_write(5'h04, 32'd0);
        run_ref(2);
        bus_write(5'h04, 32'd100);
        bus_read(5'h04, rd); check("R10 load", rd, 32'd100);
        run_ref(3);
        bus_read(5'h04, rd); check("R10 restart short", rd, 32'd100);
        run_ref(1);
        bus_read(5'h04, rd); check("R10 restart exact", rd, 32'd101);

        // flags: C=0, alarm 5, start at 3
        bus_write(5'h08, 32'h0);
        bus_write(5'h10, 32'h3);
        bus_write(5'h00, 32'd5);
        bus_write(5'h04, 32'd5);
        bus_read(5'h10, rd); check("R7 load equal no alarm", rd, 32'h0);
        bus_write(5'h04, 32'd3);
        run_ref(1);
        bus_read(5'h10, rd); check("R6 tick flag", rd, 32'h2);
        check("R9 irq disabled", {31'b0, irq}, 32'h0);
        bus_write(5'h10, 32'h2);
        bus_read(5'h10, rd); check("R8 clear tick", rd, 32'h0);
        run_ref(1);
        bus_read(5'h10, rd); check("R7 alarm match", rd, 32'h3);
        bus_write(5'h10, 32'h4);
        bus_read(5'h10, rd); check("R8 zero write keeps flags", rd, 32'h7);
        check("R9 alarm irq", {31'b0, irq}, 32'h1);
        bus_write(5'h10, 32'h5);
        bus_read(5'h10, rd); check("R8 clear alarm", rd, 32'h6);
        check("R9 irq drops", {31'b0, irq}, 32'h0);
        bus_write(5'h10, 32'hC);
        check("R9 tick irq", {31'b0, irq}, 32'h1);
        bus_write(5'h10, 32'hE);
        bus_read(5'h10, rd); check("R9 enables kept", rd, 32'hC);
        check("R9 irq clear", {31'b0, irq}, 32'h0);
        run_ref(1);
        bus_read(5'h10, rd); check("R7 no alarm off match", rd, 32'hE);

        // R11 decode and trim layout
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_read(5'h08, rd); check("R11 trim fields", rd, 32'h03FF_FFFF);
        bus_read(5'h0C, rd); check("R11 unmapped", rd, 32'h0);
        bus_read(5'h00, rd); check("R11 alarm offset", rd, 32'd5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule